// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block connects a 32-bit core's memory-access stage to a word-wide memory bus. On the request side it receives the access size code, the effective byte address and the register value to be written. From these it produces a word address, one enable per byte lane and write data arranged across the lanes. The byte order is little-endian: the byte at the lowest address travels on lane 0, which is bits 7:0. The request path is purely combinational, so the memory sees the lane-mapped request in the same cycle the core presents it.

For loads, the memory returns a whole word, one or more cycles after the request. The block stores the byte offset and size code of the last accepted load request. When the response arrives, it uses that stored context to pick out the addressed byte, half word or word. The result is sign-extended or zero-extended to 32 bits. A request with an unknown size code, or one whose address breaks the alignment rule for its size, is flagged. Such a request gets no byte enables and is never split into two accesses.

Top module: `lsu_align`

## Requirements
- R1: `mem_addr_o` equals `req_addr_i` with bits 1:0 forced to zero.
- R2: A valid byte access (funct3 000 for stores, 000 or 100 for loads) at offset k = addr[1:0] drives enable bit k alone. For a store, every lane of `mem_wdata_o` carries `req_wdata_i[7:0]`.
- R3: A valid half-word access (funct3 001 for stores, 001 or 101 for loads) at offset 0 or 2 drives enables 0011 or 1100. For a store, both half-word lanes of `mem_wdata_o` carry `req_wdata_i[15:0]`.
- R4: A valid word access (funct3 010) at offset 0 drives enables 1111. For a store, `mem_wdata_o` equals `req_wdata_i`.
- R5: A half word at an odd address, or a word at an address that is not a multiple of 4, raises `req_err_o` and forces `mem_be_o` to 0000.
- R6: A funct3 outside {000,001,010} on a store, or outside {000,001,010,100,101} on a load, raises `req_err_o` and forces `mem_be_o` to 0000.
- R7: With `req_valid_i` low, `mem_be_o` is 0000 and `req_err_o` is 0.
- R8: A byte load returns byte lane k of the response word, extended to 32 bits. The extension copies bit 7 for funct3 000 and fills with zeros for funct3 100.
- R9: A half-word load returns lanes k+1:k of the response word, extended to 32 bits. The extension copies bit 15 for funct3 001 and fills with zeros for funct3 101.
- R10: A word load (funct3 010) returns the response word unchanged.
- R11: The offset and funct3 used for extraction are captured at each clock edge where a load request is valid and free of error. Store requests and faulty loads leave them unchanged. After reset they hold offset 0 and funct3 010.
- R12: `load_data_o` is zero whenever `rsp_valid_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| req_store_i | input | 1 | 1 for a store, 0 for a load |
| req_funct3_i | input | 3 | Size and extension code |
| req_addr_i | input | 32 | Effective byte address |
| req_wdata_i | input | 32 | Store source value |
| mem_addr_o | output | 32 | Word-aligned bus address |
| mem_be_o | output | 4 | Per-lane byte enables |
| mem_wdata_o | output | 32 | Lane-mapped write data |
| req_err_o | output | 1 | Misaligned or illegal request |
| rsp_valid_i | input | 1 | Load response word present |
| rsp_rdata_i | input | 32 | Load response word |
| load_data_o | output | 32 | Extracted and extended load result |

## Verification
A wrong enable mask or a wrong lane mapping shows up at `mem_be_o` and `mem_wdata_o` in the same cycle as the request, because that path has no registers. A fault in the stored load context shows up only when the response is extracted. The bench therefore places the response in the cycle after the request, and also after an intervening store and a faulty load. A context that was overwritten, or never captured, then returns the wrong lane or the wrong extension. Each size is tested at several offsets, with response words whose sign bits differ from lane to lane, so a wrong lane choice or a wrong extension changes the result.

// File: rtl/lsu_align_pkg.sv
package lsu_align_pkg;

  localparam logic [2:0] F3_B  = 3'b000;
  localparam logic [2:0] F3_H  = 3'b001;
  localparam logic [2:0] F3_W  = 3'b010;
  localparam logic [2:0] F3_BU = 3'b100;
  localparam logic [2:0] F3_HU = 3'b101;

  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD, SZ_NONE} size_e;

  function automatic size_e size_of(logic [1:0] code);
    case (code)
      2'b00:   return SZ_BYTE;
      2'b01:   return SZ_HALF;
      2'b10:   return SZ_WORD;
      default: return SZ_NONE;
    endcase
  endfunction

endpackage

// File: rtl/lsu_lane_map.sv
module lsu_lane_map
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic              valid_i,
  input  logic              store_i,
  input  logic [2:0]        f3_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [NB-1:0]     be_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              err_o
);

  size_e         sz;
  logic          legal;
  logic          aligned;
  logic [NB-1:0] base;

  always_comb begin
    sz = size_of(f3_i[1:0]);
    if (store_i) legal = (f3_i == F3_B) || (f3_i == F3_H) || (f3_i == F3_W);
    else         legal = (f3_i == F3_B) || (f3_i == F3_H) || (f3_i == F3_W) ||
                         (f3_i == F3_BU) || (f3_i == F3_HU);
    case (sz)
      SZ_BYTE: aligned = 1'b1;
      SZ_HALF: aligned = ~off_i[0];
      SZ_WORD: aligned = (off_i == '0);
      default: aligned = 1'b0;
    endcase
    err_o = valid_i && !(legal && aligned);
    case (sz)
      SZ_BYTE: base = NB'(1);
      SZ_HALF: base = NB'(3);
      default: base = '1;
    endcase
    be_o = (valid_i && !err_o) ? (base << off_i) : '0;
  end

  // each lane takes a fixed source byte per size: replication, no shifter
  for (genvar i = 0; i < NB; i++) begin : g_lane
    always_comb begin
      case (sz)
        SZ_BYTE: wdata_o[8*i +: 8] = wdata_i[7:0];
        SZ_HALF: wdata_o[8*i +: 8] = wdata_i[8*(i%2) +: 8];
        default: wdata_o[8*i +: 8] = wdata_i[8*i +: 8];
      endcase
    end
  end

endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_align_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic [2:0]        f3_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic [DATA_W-1:0] data_o
);

  logic [DATA_W-1:0] shifted;
  logic [7:0]        b;
  logic [15:0]       h;

  always_comb begin
    shifted = rdata_i >> {off_i, 3'b000};
    b       = shifted[7:0];
    h       = shifted[15:0];
    case (f3_i)
      F3_B:    data_o = {{(DATA_W-8){b[7]}}, b};
      F3_BU:   data_o = {{(DATA_W-8){1'b0}}, b};
      F3_H:    data_o = {{(DATA_W-16){h[15]}}, h};
      F3_HU:   data_o = {{(DATA_W-16){1'b0}}, h};
      default: data_o = rdata_i;
    endcase
  end

endmodule

// File: rtl/lsu_align.sv
module lsu_align
  import lsu_align_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_store_i,
  input  logic [2:0]        req_funct3_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [NB-1:0]     mem_be_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              req_err_o,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_rdata_i,
  output logic [DATA_W-1:0] load_data_o
);

  logic [OFF_W-1:0]  ctx_off_q;
  logic [2:0]        ctx_f3_q;
  logic [DATA_W-1:0] ext_data;
  logic              load_take;

  assign mem_addr_o = {req_addr_i[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};

  lsu_lane_map #(.DATA_W(DATA_W)) i_lane_map (
    .valid_i (req_valid_i),
    .store_i (req_store_i),
    .f3_i    (req_funct3_i),
    .off_i   (req_addr_i[OFF_W-1:0]),
    .wdata_i (req_wdata_i),
    .be_o    (mem_be_o),
    .wdata_o (mem_wdata_o),
    .err_o   (req_err_o)
  );

  assign load_take = req_valid_i && !req_store_i && !req_err_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctx_off_q <= '0;
      ctx_f3_q  <= F3_W;
    end else if (load_take) begin
      ctx_off_q <= req_addr_i[OFF_W-1:0];
      ctx_f3_q  <= req_funct3_i;
    end
  end

  lsu_load_extract #(.DATA_W(DATA_W)) i_extract (
    .f3_i    (ctx_f3_q),
    .off_i   (ctx_off_q),
    .rdata_i (rsp_rdata_i),
    .data_o  (ext_data)
  );

  assign load_data_o = rsp_valid_i ? ext_data : '0;

endmodule

// File: rtl/lsu_align_chk.sv
module lsu_align_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_store_i,
  input logic [2:0]        req_funct3_i,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [DATA_W-1:0] req_wdata_i,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [NB-1:0]     mem_be_o,
  input logic [DATA_W-1:0] mem_wdata_o,
  input logic              req_err_o,
  input logic              rsp_valid_i,
  input logic [DATA_W-1:0] load_data_o
);

  // R1
  addr_word_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> (mem_addr_o[OFF_W-1:0] == '0) &&
                    (mem_addr_o[ADDR_W-1:OFF_W] == req_addr_i[ADDR_W-1:OFF_W]));

  // R5 R6
  err_no_be_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_err_o |-> (mem_be_o == '0));

  // R7
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> (mem_be_o == '0) && !req_err_o);

  // R2
  byte_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_funct3_i[1:0] == 2'b00 && !req_err_o) |-> ($countones(mem_be_o) == 1));

  // R4
  word_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_store_i && req_funct3_i == 3'b010 && !req_err_o) |->
      (mem_wdata_o == req_wdata_i) && (mem_be_o == '1));

  // R12
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rsp_valid_i |-> (load_data_o == '0));

endmodule

bind lsu_align lsu_align_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_store_i  (req_store_i),
  .req_funct3_i (req_funct3_i),
  .req_addr_i   (req_addr_i),
  .req_wdata_i  (req_wdata_i),
  .mem_addr_o   (mem_addr_o),
  .mem_be_o     (mem_be_o),
  .mem_wdata_o  (mem_wdata_o),
  .req_err_o    (req_err_o),
  .rsp_valid_i  (rsp_valid_i),
  .load_data_o  (load_data_o)
);

// File: tb/test_lsu_align.sv
module test_lsu_align;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_store_i = 1'b0;
  logic [2:0]  req_funct3_i = 3'b000;
  logic [31:0] req_addr_i = '0;
  logic [31:0] req_wdata_i = '0;
  logic [31:0] mem_addr_o;
  logic [3:0]  mem_be_o;
  logic [31:0] mem_wdata_o;
  logic        req_err_o;
  logic        rsp_valid_i = 1'b0;
  logic [31:0] rsp_rdata_i = '0;
  logic [31:0] load_data_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  lsu_align i_lsu_align (
    .clk_i, .rst_ni, .req_valid_i, .req_store_i, .req_funct3_i, .req_addr_i,
    .req_wdata_i, .mem_addr_o, .mem_be_o, .mem_wdata_o, .req_err_o,
    .rsp_valid_i, .rsp_rdata_i, .load_data_o
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic t_reset();
    @(negedge clk_i);
    rsp_valid_i = 1'b1; rsp_rdata_i = 32'hA5A5_1234;
    #1 chk("R11 reset ctx word", load_data_o, 32'hA5A5_1234);
    rsp_valid_i = 1'b0;
    #1 chk("R12 no rsp zero", load_data_o, 32'h0);
    chk("R7 idle be", {28'h0, mem_be_o}, 32'h0);
    chk("R7 idle err", {31'h0, req_err_o}, 32'h0);
  endtask

  task automatic t_store(string tag, logic [2:0] f3, logic [31:0] addr, logic [31:0] wd,
                         logic [3:0] exp_be, logic [31:0] exp_wd, logic exp_err);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_store_i = 1'b1; req_funct3_i = f3;
    req_addr_i = addr; req_wdata_i = wd;
    #1;
    chk({tag, " be"}, {28'h0, mem_be_o}, {28'h0, exp_be});
    chk({tag, " err"}, {31'h0, req_err_o}, {31'h0, exp_err});
    chk("R1 addr", mem_addr_o, {addr[31:2], 2'b00});
    if (!exp_err) chk({tag, " wdata"}, mem_wdata_o, exp_wd);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  task automatic t_load(string tag, logic [2:0] f3, logic [31:0] addr, logic [31:0] rd,
                        logic [3:0] exp_be, logic [31:0] exp_d);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_store_i = 1'b0; req_funct3_i = f3; req_addr_i = addr;
    #1;
    chk({tag, " be"}, {28'h0, mem_be_o}, {28'h0, exp_be});
    chk({tag, " err"}, {31'h0, req_err_o}, 32'h0);
    @(negedge clk_i);
    req_valid_i = 1'b0; rsp_valid_i = 1'b1; rsp_rdata_i = rd;
    #1 chk({tag, " data"}, load_data_o, exp_d);
    rsp_valid_i = 1'b0;
  endtask

  task automatic t_load_err(string tag, logic [2:0] f3, logic [31:0] addr);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_store_i = 1'b0; req_funct3_i = f3; req_addr_i = addr;
    #1;
    chk({tag, " err"}, {31'h0, req_err_o}, 32'h1);
    chk({tag, " be"}, {28'h0, mem_be_o}, 32'h0);
    @(negedge clk_i);
    req_valid_i = 1'b0;
  endtask

  // R11: context survives a store and a faulty load
  task automatic t_ctx_hold();
    @(negedge clk_i);
    req_valid_i = 1'b1; req_store_i = 1'b0; req_funct3_i = 3'b100; req_addr_i = 32'h0000_0303;
    @(negedge clk_i);
    req_store_i = 1'b1; req_funct3_i = 3'b000; req_addr_i = 32'h0000_0010; req_wdata_i = 32'h55;
    @(negedge clk_i);
    req_store_i = 1'b0; req_funct3_i = 3'b111; req_addr_i = 32'h0000_0020;
    @(negedge clk_i);
    req_valid_i = 1'b0; rsp_valid_i = 1'b1; rsp_rdata_i = 32'h9C00_00FF;
    #1 chk("R11 ctx held", load_data_o, 32'h0000_009C);
    rsp_valid_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=timeout exp=done");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    // R2 R1
    t_store("R2 sb off3", 3'b000, 32'h0000_0103, 32'h1122_33C4, 4'b1000, 32'hC4C4_C4C4, 1'b0);
    t_store("R2 sb off0", 3'b000, 32'h0000_0100, 32'h1122_3307, 4'b0001, 32'h0707_0707, 1'b0);
    t_store("R2 sb off1", 3'b000, 32'h0000_0101, 32'h0000_0011, 4'b0010, 32'h1111_1111, 1'b0);
    // R3
    t_store("R3 sh off2", 3'b001, 32'h0000_0202, 32'hAAAA_BEEF, 4'b1100, 32'hBEEF_BEEF, 1'b0);
    t_store("R3 sh off0", 3'b001, 32'h0000_0200, 32'h1234_5678, 4'b0011, 32'h5678_5678, 1'b0);
    // R4
    t_store("R4 sw", 3'b010, 32'h0000_0304, 32'hDEAD_BEEF, 4'b1111, 32'hDEAD_BEEF, 1'b0);
    // R5
    t_store("R5 sh odd", 3'b001, 32'h0000_0201, 32'h0, 4'b0000, 32'h0, 1'b1);
    t_store("R5 sw off2", 3'b010, 32'h0000_0302, 32'h0, 4'b0000, 32'h0, 1'b1);
    t_load_err("R5 lw off1", 3'b010, 32'h0000_0301);
    t_load_err("R5 lhu off3", 3'b101, 32'h0000_0303);
    // R6
    t_store("R6 st f3 011", 3'b011, 32'h0000_0100, 32'h0, 4'b0000, 32'h0, 1'b1);
    t_store("R6 st f3 100", 3'b100, 32'h0000_0100, 32'h0, 4'b0000, 32'h0, 1'b1);
    t_load_err("R6 ld f3 110", 3'b110, 32'h0000_0100);
    // R8
    t_load("R8 lb off0", 3'b000, 32'h0000_0400, 32'h80F1_7F82, 4'b0001, 32'hFFFF_FF82);
    t_load("R8 lbu off0", 3'b100, 32'h0000_0400, 32'h80F1_7F82, 4'b0001, 32'h0000_0082);
    t_load("R8 lb off1", 3'b000, 32'h0000_0401, 32'h80F1_7F82, 4'b0010, 32'h0000_007F);
    t_load("R8 lb off2", 3'b000, 32'h0000_0402, 32'h80F1_7F82, 4'b0100, 32'hFFFF_FFF1);
    t_load("R8 lbu off3", 3'b100, 32'h0000_0403, 32'h80F1_7F82, 4'b1000, 32'h0000_0080);
    // R9
    t_load("R9 lh off0", 3'b001, 32'h0000_0400, 32'h80F1_7F82, 4'b0011, 32'h0000_7F82);
    t_load("R9 lh off2", 3'b001, 32'h0000_0402, 32'h80F1_7F82, 4'b1100, 32'hFFFF_80F1);
    t_load("R9 lhu off2", 3'b101, 32'h0000_0402, 32'h80F1_7F82, 4'b1100, 32'h0000_80F1);
    // R10
    t_load("R10 lw", 3'b010, 32'h0000_0404, 32'h80F1_7F82, 4'b1111, 32'h80F1_7F82);
    t_ctx_hold();
    #1 chk("R12 idle after rsp", load_data_o, 32'h0);
    done = 1'b1;
    finish_run();
  end

endmodule